// File: doc/BRIEF.md
# Transmit Channel-Status and User-Bit Source

This block supplies the channel status bit and the user bit for each subframe of an outgoing two-channel serial audio stream. The framer sends a one-cycle strobe for every subframe. With the strobe it states whether the subframe is for channel B, and whether the subframe opens a 192-frame block, which is the frame that carries the Z preamble. The block returns the two bits for that subframe on registered outputs. The framer puts them into the subframe. Biphase coding and preamble generation stay in the framer.

Status bits come from two 192-bit images, one for channel A and one for channel B. The host fills them through a byte-write port, and a select input steers each byte to the A or the B image. At each block start the host images are copied into the live images, unless the copy is held off. The live images are sent again in every block, so the host does nothing while the status is unchanged. An option sends the A image on both channels.

User bits come from two 384-bit buffers. One buffer is sent while the host refills the other. When the buffer being sent runs out, the two swap, and a pulse names the buffer that was emptied. Sending can start at once, or it can wait for the next block start.

Top module: `txaux_status_user`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears every image and both user buffers, makes buffer 0 the one being sent, and drives cs_bit, u_bit, usr_empty_pulse and usr_empty_idx to 0 on the next cycle.
- R2: A write with wr_en=1 and wr_tgt=0 to byte address 0..23 stores wr_data into the host status image chosen by cs_chan_sel (0 = A, 1 = B). A status write to any other address changes nothing.
- R3: Status bit n (n = 0..191) is bit n%8 of byte n/8. The frame counter goes up by one on each channel-A subframe and is 0 on the subframe that opens a block. A channel-B subframe uses the same n as the channel-A subframe before it. With no block start, the counter wraps from 191 to 0.
- R4: A channel-A subframe that has sf_block_start=1 and cs_copy_hold=0 loads both live images from the host images. The load uses the host contents from before any write in the same cycle, and it applies from that subframe onward.
- R5: While cs_copy_hold=1, the live images keep their contents, and every following block repeats the same status bits.
- R6: With cs_ab_same=1, channel-B subframes take their status bit from the A image.
- R7: cs_bit and u_bit change only in the cycle after a strobe, and they hold their values between strobes.
- R8: When usr_mode is not 01 (codes 00, 10 and 11), u_bit is 0 for every subframe and the read position returns to bit 0.
- R9: In usr_mode 01, one user bit is sent on every subframe of either channel. Bit p (p = 0..383) of the buffer being sent is bit p%8 of byte p/8.
- R10: If usr_z_align=0, sending starts with the first strobe in mode 01. If usr_z_align=1, u_bit stays 0 until a channel-A subframe that opens a block, and sending starts with that subframe.
- R11: After bit 383 has been sent, the other buffer becomes the one being sent. usr_empty_pulse is high for one cycle, and usr_empty_idx shows the index of the buffer just emptied and holds it until the next swap.
- R12: A write with wr_en=1 and wr_tgt=1 to byte address 0..47 goes to the buffer that is not being sent after that cycle. A write in the cycle of a swap therefore lands in the buffer just emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host byte write |
| wr_tgt | input | 1 | Write target: 0 = status image, 1 = user buffer |
| wr_addr | input | ADDR_W | Byte address |
| wr_data | input | 8 | Byte to write |
| cs_chan_sel | input | 1 | Status write destination: 0 = A image, 1 = B image |
| cs_ab_same | input | 1 | Send the A image on both channels |
| cs_copy_hold | input | 1 | Block the copy from host to live images |
| usr_mode | input | 2 | User source: 01 = host buffers, any other code = zeros |
| usr_z_align | input | 1 | Wait for a block start before sending user bits |
| sf_strobe | input | 1 | One cycle per outgoing subframe |
| sf_chan_b | input | 1 | The subframe is for channel B |
| sf_block_start | input | 1 | The subframe opens a block (Z preamble) |
| cs_bit | output | 1 | Status bit for the last strobed subframe |
| u_bit | output | 1 | User bit for the last strobed subframe |
| usr_empty_pulse | output | 1 | One-cycle pulse when a user buffer has been sent in full |
| usr_empty_idx | output | 1 | Index of the buffer emptied most recently |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a host status write arrives in the cycle of a block-start copy. R4 says the live image takes the old byte, so the new byte may appear only from the following block on. In the second pair, a host user write arrives in the cycle of a buffer swap, and the byte must land in the buffer just emptied. The bench forces both. It places a status write on the block-start strobe itself. In another phase it writes one user byte with every strobe across several swaps. A behavioural reference model in the bench predicts all four outputs, and they are compared on every cycle.

// File: rtl/txaux_pkg.sv
// Package txaux_pkg
// Types and constants shared by the transmit status and user-bit source.
// Assumes: byte-wide host writes.
package txaux_pkg;

    localparam int BYTE_W = 8;

    // Codes for the user-bit source
    typedef enum logic [1:0] {
        UMODE_ZERO  = 2'b00,
        UMODE_HOST  = 2'b01,
        UMODE_RSV_A = 2'b10,
        UMODE_RSV_B = 2'b11
    } umode_e;

endpackage

// File: rtl/txaux_cs_store.sv
// Module txaux_cs_store
// Holds the host and live channel-status images for channels A and B.
// Picks the status bit for each strobed subframe.
// Assumes: sf_block_start counts only on a channel-A subframe. The copy from
// host to live images bypasses into the same subframe, so a block never mixes
// old and new status bits.
module txaux_cs_store
    import txaux_pkg::*;
#(
    parameter int CS_BYTES = 24,
    parameter int ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              sel_b,
    input  logic              copy_hold,
    input  logic              ab_same,
    input  logic              sf_strobe,
    input  logic              sf_chan_b,
    input  logic              sf_block_start,
    output logic              cs_bit
);

    localparam int CS_BITS = CS_BYTES * BYTE_W;
    localparam int IDX_W   = $clog2(CS_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CS_BITS - 1);

    logic                          copy_now;
    logic                          pick_b;
    logic [IDX_W-1:0]              frame_q;
    logic [IDX_W-1:0]              frame_cur;
    logic [1:0][CS_BITS-1:0]       src_img;

    assign copy_now = sf_strobe && sf_block_start && !sf_chan_b && !copy_hold;
    assign pick_b   = sf_chan_b && !ab_same;

    // One host/live pair of images per channel
    generate
        for (genvar ch = 0; ch < 2; ch++) begin : g_chan
            localparam logic IS_B = (ch == 1);
            logic [CS_BITS-1:0] host_q;
            logic [CS_BITS-1:0] live_q;
            logic               ch_wr;

            assign ch_wr = wr_en && (sel_b == IS_B);

            // Host image: store the addressed byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    host_q <= '0;
                end else if (ch_wr) begin
                    for (int k = 0; k < CS_BYTES; k++) begin
                        if (wr_addr == ADDR_W'(k)) begin
                            host_q[BYTE_W*k +: BYTE_W] <= wr_data;
                        end
                    end
                end
            end

            // Live image: load at a block start unless held
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    live_q <= '0;
                end else if (copy_now) begin
                    live_q <= host_q;
                end
            end

            assign src_img[ch] = copy_now ? host_q : live_q;
        end
    endgenerate

    // Frame index for this subframe: reset at block start, step on channel A
    always_comb begin
        frame_cur = frame_q;
        if (!sf_chan_b) begin
            if (sf_block_start || (frame_q == IDX_LAST)) begin
                frame_cur = '0;
            end else begin
                frame_cur = frame_q + 1'b1;
            end
        end
    end

    // Register the frame index and the chosen status bit on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= IDX_LAST;
            cs_bit  <= 1'b0;
        end else if (sf_strobe) begin
            frame_q <= frame_cur;
            cs_bit  <= src_img[pick_b][frame_cur];
        end
    end

endmodule

// File: rtl/txaux_user_store.sv
// Module txaux_user_store
// Double-buffered user-bit source. One buffer is sent, one bit per subframe,
// while the host fills the other. The two swap when the sent buffer runs out.
// Assumes: host writes always target the buffer that is idle after the
// current cycle.
module txaux_user_store
    import txaux_pkg::*;
#(
    parameter int USR_BYTES = 48,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        mode,
    input  logic              z_align,
    input  logic              sf_strobe,
    input  logic              sf_chan_b,
    input  logic              sf_block_start,
    output logic              u_bit,
    output logic              empty_pulse,
    output logic              empty_idx
);

    localparam int USR_BITS = USR_BYTES * BYTE_W;
    localparam int POS_W    = $clog2(USR_BITS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(USR_BITS - 1);

    umode_e           mode_e;
    logic             act_q;
    logic             run_q;
    logic [POS_W-1:0] pos_q;
    logic             host_on;
    logic             send_now;
    logic             swap_now;
    logic             back_buf;
    logic [1:0]       rd_bit;

    assign mode_e   = umode_e'(mode);
    assign host_on  = (mode_e == UMODE_HOST);
    assign send_now = sf_strobe && host_on &&
                      (run_q || !z_align || (sf_block_start && !sf_chan_b));
    assign swap_now = send_now && (pos_q == POS_LAST);
    assign back_buf = swap_now ? act_q : !act_q;

    // The two user buffers, each written only while it is the idle one
    generate
        for (genvar b = 0; b < 2; b++) begin : g_buf
            localparam logic BUF_ID = (b == 1);
            logic [USR_BITS-1:0] store_q;

            // Buffer fill from the host byte port
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store_q <= '0;
                end else if (wr_en && (back_buf == BUF_ID)) begin
                    for (int k = 0; k < USR_BYTES; k++) begin
                        if (wr_addr == ADDR_W'(k)) begin
                            store_q[BYTE_W*k +: BYTE_W] <= wr_data;
                        end
                    end
                end
            end

            assign rd_bit[b] = store_q[pos_q];
        end
    endgenerate

    // Read position, running flag and active buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            run_q <= 1'b0;
            pos_q <= '0;
        end else if (sf_strobe) begin
            if (!host_on) begin
                run_q <= 1'b0;
                pos_q <= '0;
            end else if (send_now) begin
                run_q <= 1'b1;
                pos_q <= swap_now ? '0 : pos_q + 1'b1;
                act_q <= act_q ^ swap_now;
            end
        end
    end

    // Output bit, the swap pulse and the emptied-buffer index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_bit       <= 1'b0;
            empty_pulse <= 1'b0;
            empty_idx   <= 1'b0;
        end else begin
            empty_pulse <= swap_now;
            if (swap_now) begin
                empty_idx <= act_q;
            end
            if (sf_strobe) begin
                u_bit <= send_now ? rd_bit[act_q] : 1'b0;
            end
        end
    end

endmodule

// File: rtl/txaux_status_user.sv
// Module txaux_status_user (top)
// Source of the channel-status and user bits for each outgoing subframe.
// Splits the host byte port between the status images and the user buffers.
// Assumes: the framer strobes each subframe once and flags block start on the
// channel-A subframe that carries the Z preamble.
module txaux_status_user
    import txaux_pkg::*;
#(
    parameter int CS_BYTES  = 24,
    parameter int USR_BYTES = 48,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_tgt,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cs_chan_sel,
    input  logic              cs_ab_same,
    input  logic              cs_copy_hold,
    input  logic [1:0]        usr_mode,
    input  logic              usr_z_align,
    input  logic              sf_strobe,
    input  logic              sf_chan_b,
    input  logic              sf_block_start,
    output logic              cs_bit,
    output logic              u_bit,
    output logic              usr_empty_pulse,
    output logic              usr_empty_idx
);

    logic cs_wr;
    logic usr_wr;

    assign cs_wr  = wr_en && !wr_tgt;
    assign usr_wr = wr_en && wr_tgt;

    txaux_cs_store #(
        .CS_BYTES (CS_BYTES),
        .ADDR_W   (ADDR_W)
    ) u_cs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (cs_wr),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .sel_b          (cs_chan_sel),
        .copy_hold      (cs_copy_hold),
        .ab_same        (cs_ab_same),
        .sf_strobe      (sf_strobe),
        .sf_chan_b      (sf_chan_b),
        .sf_block_start (sf_block_start),
        .cs_bit         (cs_bit)
    );

    txaux_user_store #(
        .USR_BYTES (USR_BYTES),
        .ADDR_W    (ADDR_W)
    ) u_usr (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (usr_wr),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .mode           (usr_mode),
        .z_align        (usr_z_align),
        .sf_strobe      (sf_strobe),
        .sf_chan_b      (sf_chan_b),
        .sf_block_start (sf_block_start),
        .u_bit          (u_bit),
        .empty_pulse    (usr_empty_pulse),
        .empty_idx      (usr_empty_idx)
    );

endmodule

// File: rtl/txaux_status_user_chk.sv
// Module txaux_status_user_chk
// Port-level properties of txaux_status_user, attached to it by bind.
// Assumes: synchronous active-low reset.
module txaux_status_user_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] usr_mode,
    input logic       sf_strobe,
    input logic       cs_bit,
    input logic       u_bit,
    input logic       usr_empty_pulse,
    input logic       usr_empty_idx
);

    // R1: a reset edge clears the outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!cs_bit && !u_bit && !usr_empty_pulse && !usr_empty_idx));

    // R7: outputs hold between strobes
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_strobe |=> ($stable(cs_bit) && $stable(u_bit)));

    // R8: modes other than 01 send zero user bits
    p_zero_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_strobe && usr_mode != 2'b01) |=> !u_bit);

    // R11: the swap pulse lasts one cycle
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        usr_empty_pulse |=> !usr_empty_pulse);

    // R11: a swap pulse follows a strobe in host-buffer mode
    p_pulse_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usr_empty_pulse) |-> $past(sf_strobe && usr_mode == 2'b01));

    // R11: the emptied-buffer index changes only together with the pulse
    p_idx_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !usr_empty_pulse |-> $stable(usr_empty_idx));

endmodule

bind txaux_status_user txaux_status_user_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .usr_mode        (usr_mode),
    .sf_strobe       (sf_strobe),
    .cs_bit          (cs_bit),
    .u_bit           (u_bit),
    .usr_empty_pulse (usr_empty_pulse),
    .usr_empty_idx   (usr_empty_idx)
);

// File: tb/txaux_status_user_test.sv
// Bench for txaux_status_user. A behavioural reference model predicts every
// output, and the outputs are compared with it on every cycle.
module txaux_status_user_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCS  = 192;
    localparam int NUSR = 384;
    localparam int WATCHDOG = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_tgt = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cs_chan_sel = 1'b0;
    logic       cs_ab_same = 1'b0;
    logic       cs_copy_hold = 1'b0;
    logic [1:0] usr_mode = 2'b00;
    logic       usr_z_align = 1'b0;
    logic       sf_strobe = 1'b0;
    logic       sf_chan_b = 1'b0;
    logic       sf_block_start = 1'b0;
    logic       cs_bit, u_bit, usr_empty_pulse, usr_empty_idx;

    txaux_status_user uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_addr(wr_addr), .wr_data(wr_data), .cs_chan_sel(cs_chan_sel),
        .cs_ab_same(cs_ab_same), .cs_copy_hold(cs_copy_hold),
        .usr_mode(usr_mode), .usr_z_align(usr_z_align),
        .sf_strobe(sf_strobe), .sf_chan_b(sf_chan_b),
        .sf_block_start(sf_block_start), .cs_bit(cs_bit), .u_bit(u_bit),
        .usr_empty_pulse(usr_empty_pulse), .usr_empty_idx(usr_empty_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    logic [NCS-1:0]  m_host [2];
    logic [NCS-1:0]  m_live [2];
    logic [NUSR-1:0] m_ubuf [2];
    integer m_fidx, m_upos;
    logic   m_uact, m_urun;
    logic   e_cs, e_u, e_pulse, e_idx;

    always @(posedge clk) begin : model
        integer ch;
        if (!rst_n) begin
            m_host[0] = '0; m_host[1] = '0; m_live[0] = '0; m_live[1] = '0;
            m_ubuf[0] = '0; m_ubuf[1] = '0;
            m_fidx = NCS - 1; m_upos = 0; m_uact = 0; m_urun = 0;
            e_cs = 0; e_u = 0; e_pulse = 0; e_idx = 0;
        end else begin
            e_pulse = 0;
            if (sf_strobe) begin
                if (!sf_chan_b) m_fidx = sf_block_start ? 0 : (m_fidx + 1) % NCS;
                if (sf_block_start && !sf_chan_b && !cs_copy_hold) begin
                    m_live[0] = m_host[0]; m_live[1] = m_host[1];
                end
                ch = (sf_chan_b && !cs_ab_same) ? 1 : 0;
                e_cs = m_live[ch][m_fidx];
                if (usr_mode == 2'b01) begin
                    if (m_urun || !usr_z_align || (sf_block_start && !sf_chan_b)) begin
                        m_urun = 1;
                        e_u = m_ubuf[m_uact][m_upos];
                        if (m_upos == NUSR - 1) begin
                            m_upos = 0; e_pulse = 1; e_idx = m_uact; m_uact = !m_uact;
                        end else m_upos = m_upos + 1;
                    end else e_u = 0;
                end else begin
                    e_u = 0; m_urun = 0; m_upos = 0;
                end
            end
            if (wr_en) begin
                for (int i = 0; i < 8; i++) begin
                    if (!wr_tgt && wr_addr < 24) m_host[cs_chan_sel][wr_addr*8+i] = wr_data[i];
                    if (wr_tgt && wr_addr < 48) m_ubuf[!m_uact][wr_addr*8+i] = wr_data[i];
                end
            end
        end
    end

    // ---------------- comparison ----------------
    integer n_cmp = 0, n_bad = 0, cyc = 0;
    logic   armed = 0, done = 0;
    string  tag = "R1";

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (armed && !done) begin
            chk(tag, "cs_bit", cs_bit, e_cs);
            chk(tag, "u_bit", u_bit, e_u);
            chk(tag, "usr_empty_pulse", usr_empty_pulse, e_pulse);
            chk(tag, "usr_empty_idx", usr_empty_idx, e_idx);
        end
        if (cyc > WATCHDOG && !done) begin
            done = 1; n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    // one strobed subframe plus one idle cycle; called at a falling edge
    task automatic sf(input logic b, input logic bs);
        sf_strobe = 1; sf_chan_b = b; sf_block_start = bs;
        @(negedge clk);
        sf_strobe = 0; sf_block_start = 0; wr_en = 0;
        @(negedge clk);
    endtask

    task automatic frame(input logic bs);
        sf(0, bs); sf(1, 0);
    endtask

    task automatic blocks(input int n);
        for (int f = 0; f < n * NCS; f++) frame(f % NCS == 0);
    endtask

    task automatic wr(input logic tgt, input logic sel, input int a, input logic [7:0] d);
        wr_en = 1; wr_tgt = tgt; cs_chan_sel = sel; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        armed = 1;
        rst_n = 1;
        // R1: state after reset
        tag = "R1";
        chk("R1", "reset cs_bit", cs_bit, 1'b0);
        chk("R1", "reset u_bit", u_bit, 1'b0);
        frame(1);

        // R2 R3 R4: distinct patterns on A and B, then sent
        tag = "R2";
        for (int k = 0; k < 24; k++) begin
            wr(0, 0, k, 8'(k * 37 + 5));
            wr(0, 1, k, 8'(k * 91 + 200));
        end
        wr(0, 0, 30, 8'hFF);               // R2 out-of-range write ignored
        tag = "R4";
        blocks(2);
        // R3: run past 192 frames without a block start
        tag = "R3";
        for (int f = 0; f < 230; f++) frame(0);

        // R5: held copy keeps the old image
        tag = "R5";
        cs_copy_hold = 1;
        for (int k = 0; k < 24; k++) wr(0, 0, k, 8'(k ^ 8'hA5));
        blocks(1);
        cs_copy_hold = 0;
        tag = "R4";
        blocks(1);

        // R6: A image on both channels
        tag = "R6";
        cs_ab_same = 1;
        blocks(1);
        cs_ab_same = 0;

        // R4: status write in the block-start cycle
        tag = "R4";
        wr_en = 1; wr_tgt = 0; cs_chan_sel = 0; wr_addr = 0; wr_data = 8'h3C;
        frame(1);
        for (int f = 1; f < NCS; f++) frame(0);
        blocks(1);

        // R12: fill the idle user buffer
        tag = "R12";
        for (int k = 0; k < 48; k++) wr(1, 0, k, 8'(k * 11 + 3));
        // R10: aligned start waits for a block start
        tag = "R10";
        usr_mode = 2'b01; usr_z_align = 1;
        for (int f = 0; f < 20; f++) frame(0);
        // R9 R11 R12: write on every strobe across several swaps
        tag = "R11";
        for (int i = 0; i < 3 * NUSR; i++) begin
            wr_en = 1; wr_tgt = 1; wr_addr = 6'((i * 7) % 48); wr_data = 8'(i) ^ 8'h5A;
            sf(i[0], (i % NUSR) == 0);
        end
        tag = "R9";
        blocks(2);

        // R8: zero modes, including a reserved code
        tag = "R8";
        usr_mode = 2'b00;
        for (int f = 0; f < 30; f++) frame(0);
        usr_mode = 2'b10;
        for (int f = 0; f < 30; f++) frame(0);
        // R10: immediate start mid-block
        tag = "R10";
        usr_mode = 2'b01; usr_z_align = 0;
        for (int f = 0; f < 500; f++) frame(f == 300);

        // R7: long idle stretch, outputs must hold
        tag = "R7";
        repeat (50) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule